// File: doc/BRIEF.md
# Serial ADC Conversion Readout Controller

This block sits on the host side of a sampling analog-to-digital converter. The converter is started by a low-going convert line and reports progress on a BUSY line. In the mode used here, the host supplies the serial data clock. When a start request arrives while the controller is idle, it holds the convert line low for a fixed number of system clocks. It then waits for BUSY to go low, which means the conversion is running, and then high again, which means the result is ready.

The converter loads its result into its output shift register just before BUSY rises. For that reason the controller produces no serial clock until it has seen BUSY high. After that it generates a divided serial clock and shifts in a 12-bit two's-complement word, most significant bit first. It presents the word, and a sign-extended copy, together with a one-cycle strobe.

BUSY and DATA pass through two-flop synchronizers before the controller uses them. Two timeouts protect the sequence: one for BUSY falling and one for BUSY rising. If either expires, the controller sets a sticky error flag and returns to idle. A chip-select output is driven low only for the readout, or tied low when the `CS_HOLD` parameter is 1.

Top module: `adc_conv_reader`

## Requirements
- R1: After reset the outputs are in their idle state: adc_conv_n_o is 1, adc_cs_n_o is 1, adc_sclk_o is 0, result_valid_o is 0, ctrl_busy_o is 0 and err_o is 0.
- R2: A start_i pulse sampled high while ctrl_busy_o is 0 drives adc_conv_n_o low for exactly CONV_CYC system clocks. This is the only way adc_conv_n_o goes low.
- R3: After the convert pulse, the controller waits for the synchronized BUSY to be low and then high. adc_sclk_o stays low until the synchronized BUSY has been seen high.
- R4: The readout consists of DATA_W serial clock periods of 2*SCLK_HALF system clocks each. In each period adc_sclk_o is low for the first half and high for the second half. Each bit is sampled at the end of the high half, MSB first. With CS_HOLD=0, adc_cs_n_o is low throughout the readout and high otherwise.
- R5: After the last bit, result_valid_o is high for exactly one cycle, and in that cycle result_o holds the received 12-bit word.
- R6: When result_valid_o is high, result_sx_o holds result_o sign-extended to OUT_W bits: bit 11 is copied into bits 15..12.
- R7: If the synchronized BUSY is not low within FALL_TO clocks after the convert pulse ends, err_o goes to 1 and the controller returns to idle with no serial clock.
- R8: If the synchronized BUSY is not high within RISE_TO clocks after it was seen low, err_o goes to 1 and the controller returns to idle with no serial clock.
- R9: err_o stays at 1 until the next accepted start request, which clears it.
- R10: While ctrl_busy_o is 1, start_i has no effect: there is no further convert pulse and the readout in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; accepted only when the controller is idle |
| adc_busy_i | input | 1 | BUSY from the converter; asynchronous to clk |
| adc_data_i | input | 1 | Serial result bit from the converter; asynchronous to clk |
| adc_conv_n_o | output | 1 | Active-low convert pulse |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_sclk_o | output | 1 | Serial data clock generated by the host |
| result_o | output | DATA_W | Received conversion word, two's complement |
| result_sx_o | output | OUT_W | Sign-extended copy of result_o |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| ctrl_busy_o | output | 1 | High from an accepted start until the controller returns to idle |
| err_o | output | 1 | Sticky BUSY timeout flag |

## Verification
The hardest cases to reach from the ports are the two timeout exits and start requests that arrive during a readout. Both depend on the converter misbehaving, or on a request landing in a narrow window. The bench therefore uses a behavioural converter model whose BUSY can be told never to fall or never to rise. It then samples err_o just before and just after each timeout window. Further start pulses are issued while waiting for BUSY and again after the first serial clock edge. The bench confirms that only one convert pulse appears and that the word received is still intact.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_WFALL = 3'd2,
    ST_WRISE = 3'd3,
    ST_SHIFT = 3'd4,
    ST_DONE  = 3'd5
  } rd_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic sample_tick
);

  localparam int PERIOD = 2 * HALF;
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] ph;
  logic            wrap;

  assign wrap = (ph == PH_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!en || wrap) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign sclk        = en && (ph >= PH_W'(HALF));
  assign sample_tick = en && wrap;

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (en) begin
      q <= {q[W-2:0], d};
    end
  end

endmodule

// File: rtl/adc_conv_reader.sv
module adc_conv_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int OUT_W     = 16,
  parameter int CONV_CYC  = 5,
  parameter int SCLK_HALF = 4,
  parameter int FALL_TO   = 32,
  parameter int RISE_TO   = 256,
  parameter int CS_HOLD   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adc_busy_i,
  input  logic              adc_data_i,
  output logic              adc_conv_n_o,
  output logic              adc_cs_n_o,
  output logic              adc_sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic [OUT_W-1:0]  result_sx_o,
  output logic              result_valid_o,
  output logic              ctrl_busy_o,
  output logic              err_o
);

  localparam int EXT_W   = OUT_W - DATA_W;
  localparam int CNT_MAX = max4(CONV_CYC, FALL_TO, RISE_TO, DATA_W);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  function automatic logic [OUT_W-1:0] sign_extend(input logic [DATA_W-1:0] v);
    return {{EXT_W{v[DATA_W-1]}}, v};
  endfunction

  rd_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             err_q;

  logic [1:0] sync_q;
  logic       busy_s;
  logic       data_s;
  logic       shift_en;
  logic       sample_tick;
  logic       sclk_int;

  // named internal events
  logic accept_start;
  logic conv_last;
  logic fall_seen;
  logic rise_seen;
  logic fall_timeout;
  logic rise_timeout;
  logic last_bit;

  adc_rd_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({adc_busy_i, adc_data_i}),
    .q     (sync_q)
  );

  assign busy_s = sync_q[1];
  assign data_s = sync_q[0];

  assign shift_en = (state == ST_SHIFT);

  adc_rd_sclk #(.HALF(SCLK_HALF)) u_sclk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (shift_en),
    .sclk        (sclk_int),
    .sample_tick (sample_tick)
  );

  adc_rd_shift #(.W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_start),
    .en    (sample_tick),
    .d     (data_s),
    .q     (result_o)
  );

  assign accept_start = (state == ST_IDLE) && start_i;
  assign conv_last    = (state == ST_CONV) && (cnt == CNT_W'(CONV_CYC - 1));
  assign fall_seen    = (state == ST_WFALL) && !busy_s;
  assign rise_seen    = (state == ST_WRISE) && busy_s;
  assign fall_timeout = (state == ST_WFALL) && busy_s && (cnt == CNT_W'(FALL_TO - 1));
  assign rise_timeout = (state == ST_WRISE) && !busy_s && (cnt == CNT_W'(RISE_TO - 1));
  assign last_bit     = sample_tick && (cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept_start) begin
            state <= ST_CONV;
            err_q <= 1'b0;
          end
        end
        ST_CONV: begin
          if (conv_last) begin
            state <= ST_WFALL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WFALL: begin
          if (fall_seen) begin
            state <= ST_WRISE;
            cnt   <= '0;
          end else if (fall_timeout) begin
            state <= ST_IDLE;
            err_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRISE: begin
          if (rise_seen) begin
            state <= ST_SHIFT;
            cnt   <= '0;
          end else if (rise_timeout) begin
            state <= ST_IDLE;
            err_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last_bit) begin
            state <= ST_DONE;
          end else if (sample_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  generate
    if (CS_HOLD != 0) begin : g_cs_tied
      assign adc_cs_n_o = 1'b0;
    end else begin : g_cs_framed
      assign adc_cs_n_o = (state != ST_SHIFT);
    end
  endgenerate

  assign adc_conv_n_o   = (state != ST_CONV);
  assign adc_sclk_o     = sclk_int;
  assign result_valid_o = (state == ST_DONE);
  assign result_sx_o    = sign_extend(result_o);
  assign ctrl_busy_o    = (state != ST_IDLE);
  assign err_o          = err_q;

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int DATA_W   = 12,
  parameter int OUT_W    = 16,
  parameter int CONV_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              adc_conv_n_o,
  input logic              adc_cs_n_o,
  input logic              adc_sclk_o,
  input logic [DATA_W-1:0] result_o,
  input logic [OUT_W-1:0]  result_sx_o,
  input logic              result_valid_o,
  input logic              ctrl_busy_o,
  input logic              err_o,
  input logic              busy_s,
  input logic              fall_timeout,
  input logic              rise_timeout
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (adc_conv_n_o) begin
      low_cnt <= '0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  p_conv_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv_n_o) |-> $past(start_i && !ctrl_busy_o));

  p_conv_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv_n_o) |-> (low_cnt == 16'(CONV_CYC)));

  p_sclk_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk_o |-> busy_s);

  p_cs_covers_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk_o |-> !adc_cs_n_o);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  p_sext_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> ((result_sx_o[DATA_W-1:0] == result_o) &&
                        (result_sx_o[OUT_W-1] == result_o[DATA_W-1])));

  p_timeout_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_timeout || rise_timeout) |=> (err_o && !ctrl_busy_o));

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(start_i && !ctrl_busy_o));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_busy_o |-> (adc_conv_n_o && !adc_sclk_o));

endmodule

bind adc_conv_reader adc_rd_checker #(
  .DATA_W   (DATA_W),
  .OUT_W    (OUT_W),
  .CONV_CYC (CONV_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .adc_conv_n_o   (adc_conv_n_o),
  .adc_cs_n_o     (adc_cs_n_o),
  .adc_sclk_o     (adc_sclk_o),
  .result_o       (result_o),
  .result_sx_o    (result_sx_o),
  .result_valid_o (result_valid_o),
  .ctrl_busy_o    (ctrl_busy_o),
  .err_o          (err_o),
  .busy_s         (busy_s),
  .fall_timeout   (fall_timeout),
  .rise_timeout   (rise_timeout)
);

// File: tb/tb_adc_conv_reader.sv
`timescale 1ns/1ps
module tb_adc_conv_reader;

  localparam int DATA_W    = 12;
  localparam int OUT_W     = 16;
  localparam int CONV_CYC  = 5;
  localparam int SCLK_HALF = 4;
  localparam int FALL_TO   = 32;
  localparam int RISE_TO   = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic dev_busy = 1'b1;
  logic dev_data = 1'b0;
  logic adc_conv_n, adc_cs_n, adc_sclk, valid, ctrl_busy, err;
  logic [DATA_W-1:0] result;
  logic [OUT_W-1:0]  result_sx;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  adc_conv_reader #(
    .DATA_W(DATA_W), .OUT_W(OUT_W), .CONV_CYC(CONV_CYC), .SCLK_HALF(SCLK_HALF),
    .FALL_TO(FALL_TO), .RISE_TO(RISE_TO), .CS_HOLD(0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .adc_busy_i(dev_busy), .adc_data_i(dev_data),
    .adc_conv_n_o(adc_conv_n), .adc_cs_n_o(adc_cs_n), .adc_sclk_o(adc_sclk),
    .result_o(result), .result_sx_o(result_sx), .result_valid_o(valid),
    .ctrl_busy_o(ctrl_busy), .err_o(err)
  );

  // ---------------- converter model ----------------
  logic [DATA_W-1:0] dev_word = '0;
  logic [DATA_W-1:0] dev_sh = '0;
  logic never_fall = 1'b0;
  logic never_rise = 1'b0;
  int   dev_phase = 0;
  int   dev_cnt = 0;
  logic m_conv_prev = 1'b1;
  logic m_sclk_prev = 1'b0;
  localparam int DEV_FALL_DLY = 3;
  localparam int DEV_CONV_T   = 60;

  always @(posedge clk) begin
    m_conv_prev <= adc_conv_n;
    m_sclk_prev <= adc_sclk;
    if (m_conv_prev && !adc_conv_n) begin
      dev_phase <= 1;
      dev_cnt   <= 0;
    end else if (dev_phase == 1) begin
      dev_cnt <= dev_cnt + 1;
      if (dev_cnt == DEV_FALL_DLY && !never_fall) begin
        dev_busy  <= 1'b0;
        dev_phase <= 2;
        dev_cnt   <= 0;
      end
    end else if (dev_phase == 2) begin
      dev_cnt <= dev_cnt + 1;
      if (dev_cnt == DEV_CONV_T && !never_rise) begin
        dev_busy  <= 1'b1;
        dev_sh    <= dev_word;
        dev_data  <= dev_word[DATA_W-1];
        dev_phase <= 0;
      end
    end
    if (m_sclk_prev && !adc_sclk) begin
      dev_sh   <= dev_sh << 1;
      dev_data <= dev_sh[DATA_W-2];
    end
  end

  // ---------------- port monitor ----------------
  int conv_low = 0, conv_falls = 0, sclk_rises = 0, since = 0, bad_period = 0;
  int cs_bad = 0, sclk_early = 0, valids = 0;
  logic [DATA_W-1:0] got = '0;
  logic [OUT_W-1:0]  got_sx = '0;
  logic p_conv = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_conv_n) conv_low++;
      if (p_conv && !adc_conv_n) conv_falls++;
      since++;
      if (adc_sclk && !p_sclk) begin
        if (sclk_rises > 0 && since != 2 * SCLK_HALF) bad_period++;
        sclk_rises++;
        since = 0;
      end
      if (adc_sclk && adc_cs_n) cs_bad++;
      if (adc_sclk && !dev_busy) sclk_early++;
      if (valid) begin
        valids++;
        got    = result;
        got_sx = result_sx;
      end
    end
    p_conv = adc_conv_n;
    p_sclk = adc_sclk;
  end

  task automatic clear_mon();
    conv_low = 0; conv_falls = 0; sclk_rises = 0; since = 0; bad_period = 0;
    cs_bad = 0; sclk_early = 0; valids = 0; got = '0; got_sx = '0;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && ctrl_busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [OUT_W-1:0] exp_sx(input logic [DATA_W-1:0] w);
    logic [OUT_W-1:0] r;
    r = OUT_W'(w);
    if (w[DATA_W-1]) r = r | ~((OUT_W'(1) << DATA_W) - 1);
    return r;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(adc_conv_n == 1'b1, "R1 conv_n", adc_conv_n, 1);
    check(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
    check(adc_sclk == 1'b0, "R1 sclk", adc_sclk, 0);
    check(valid == 1'b0 && ctrl_busy == 1'b0, "R1 valid/busy", {valid, ctrl_busy}, 0);
    check(err == 1'b0, "R1 err", err, 0);
  endtask

  task automatic t_read(input logic [DATA_W-1:0] w);
    dev_word = w;
    clear_mon();
    pulse_start();
    check(err == 1'b0, "R9 err cleared on start", err, 0);
    wait_idle();
    check(conv_low == CONV_CYC, "R2 convert width", conv_low, CONV_CYC);
    check(conv_falls == 1, "R2 one convert pulse", conv_falls, 1);
    check(sclk_early == 0, "R3 no sclk before busy high", sclk_early, 0);
    check(sclk_rises == DATA_W, "R4 sclk count", sclk_rises, DATA_W);
    check(bad_period == 0, "R4 sclk period", bad_period, 0);
    check(cs_bad == 0 && adc_cs_n == 1'b1, "R4 chip select framing", cs_bad, 0);
    check(valids == 1, "R5 single strobe", valids, 1);
    check(got == w, "R5 word MSB first", got, w);
    check(got_sx == exp_sx(w), "R6 sign extension", got_sx, exp_sx(w));
  endtask

  task automatic t_fall_timeout();
    never_fall = 1'b1;
    clear_mon();
    pulse_start();
    repeat (CONV_CYC + FALL_TO / 2) @(negedge clk);
    check(err == 1'b0 && ctrl_busy == 1'b1, "R7 still waiting", {err, ctrl_busy}, 1);
    repeat (FALL_TO / 2 + 12) @(negedge clk);
    check(err == 1'b1, "R7 fall timeout flag", err, 1);
    check(ctrl_busy == 1'b0, "R7 back to idle", ctrl_busy, 0);
    check(sclk_rises == 0, "R7 no sclk", sclk_rises, 0);
    never_fall = 1'b0;
    repeat (20) @(negedge clk);
    check(err == 1'b1, "R9 err sticky", err, 1);
  endtask

  task automatic t_rise_timeout();
    never_rise = 1'b1;
    clear_mon();
    pulse_start();
    repeat (CONV_CYC + RISE_TO / 2) @(negedge clk);
    check(err == 1'b0 && ctrl_busy == 1'b1, "R8 still waiting", {err, ctrl_busy}, 1);
    repeat (RISE_TO / 2 + 30) @(negedge clk);
    check(err == 1'b1 && ctrl_busy == 1'b0, "R8 rise timeout exit", {err, ctrl_busy}, 2);
    check(sclk_rises == 0, "R8 no sclk", sclk_rises, 0);
    never_rise = 1'b0;
    dev_busy = 1'b1;
    dev_phase = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_ignore_start(input logic [DATA_W-1:0] w);
    dev_word = w;
    clear_mon();
    pulse_start();
    repeat (10) @(negedge clk);
    check(ctrl_busy == 1'b1, "R10 busy during conversion", ctrl_busy, 1);
    pulse_start();
    for (int i = 0; i < 500 && sclk_rises == 0; i++) @(negedge clk);
    pulse_start();
    wait_idle();
    check(conv_falls == 1, "R10 extra starts ignored", conv_falls, 1);
    check(got == w && valids == 1, "R10 readout intact", got, w);
    check(sclk_rises == DATA_W, "R10 sclk count", sclk_rises, DATA_W);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(12'h7FF);
    t_read(12'h800);
    t_read(12'hA5C);
    t_read(12'h001);
    t_fall_timeout();
    t_read(12'h3C6);
    t_rise_timeout();
    t_read(12'hFFE);
    t_ignore_start(12'h96A);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule